// File: doc/BRIEF.md
# Miss Address File with Block Merging

This block tracks the data-cache misses that a load pipeline has outstanding. Each miss arrives with its physical address, an uncached flag and the load-queue tag of the requesting load. A cacheable miss is compared with every valid cacheable entry at 64-byte block granularity. If it falls in a block that an entry already holds, it takes no new entry: its tag is added to that entry's set of waiting loads. Any other miss is written into the lowest-numbered free entry. Uncached I/O misses never merge. Each one always takes an entry of its own, and later cacheable misses never merge into it.

Allocated entries are sent to the memory side one per cycle, oldest first, over a valid/ready request channel. The request carries the entry index, the block address and the uncached flag. A fill response names an entry index. In the next cycle the block pulses a wakeup carrying the full mask of load-queue tags that waited on that entry, and from then on the entry is free. When all entries are valid and a miss cannot merge, the block raises a stall and takes nothing in.

Top module: `miss_track_file`

## Requirements
- R1: After reset no entry is valid, and `req_stall`, `dn_valid` and `wake_valid` are all low.
- R2: A cacheable request whose address bits above bit 5 equal those of a valid cacheable entry is merged. It allocates nothing, sends nothing downstream, and adds its tag bit (bit `req_tag` of the mask) to that entry's waiting mask. Address bits 5..0 play no part in the comparison. At most one entry can match.
- R3: A request that does not merge, arriving while some entry is free, is accepted in the same cycle (`req_stall` low) and placed in the lowest-numbered free entry. Its waiting mask then holds only its own tag bit.
- R4: A request with `req_io` high always allocates a fresh entry, even when its block matches a held entry. An I/O entry is never a merge target. `dn_io` reports the flag of the entry being requested.
- R5: `dn_valid` is high while an allocated entry has not yet been requested. `dn_idx`, `dn_blk` (address bits above bit 5) and `dn_io` show the oldest such entry by allocation order. These outputs stay stable until a cycle in which `dn_valid` and `dn_ready` are both high, and that cycle moves the channel to the next entry.
- R6: When all entries are valid and a request does not merge, `req_stall` is high in that cycle and the request changes no state. A merging request is still accepted while the file is full.
- R7: A fill accepted in cycle t (`fill_valid` with `fill_idx`) makes `wake_valid` high for exactly cycle t+1. In that cycle `wake_mask` holds every tag recorded on the entry, including a tag merged into it in cycle t. The entry can be allocated again from cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New miss offered |
| req_addr | input | PA_W | Physical address of the miss |
| req_io | input | 1 | Miss is an uncached I/O load |
| req_tag | input | TAG_W | Load-queue tag of the requester |
| req_stall | output | 1 | Miss not accepted this cycle |
| dn_valid | output | 1 | Downstream request present |
| dn_ready | input | 1 | Downstream side takes the request |
| dn_idx | output | IDX_W | Entry index of the request |
| dn_blk | output | PA_W-6 | Block address of the request |
| dn_io | output | 1 | Request is uncached I/O |
| fill_valid | input | 1 | Fill response for an entry |
| fill_idx | input | IDX_W | Entry the fill completes |
| wake_valid | output | 1 | Wakeup pulse for waiting loads |
| wake_mask | output | TAGS | Load-queue tags satisfied by the fill |

## Verification
The assertions take three things for granted about the inputs. A fill only names an entry that is valid and has already been requested. Request addresses carry no unknown bits while `req_valid` is high. `req_valid` is never left asserted in the hope that a stalled miss will be retried, because the block keeps no memory of a refused request. The stimulus keeps within these bounds through its own model of the file: it chooses fill indices only among the entries the model has seen taken off the request channel. Addresses are drawn from a small pool of blocks with random byte offsets, so merges, I/O collisions and a full file all occur often.

// File: rtl/miss_track_pkg.sv
package miss_track_pkg;
  typedef enum logic [1:0] {
    DISP_NONE  = 2'd0,
    DISP_MERGE = 2'd1,
    DISP_ALLOC = 2'd2,
    DISP_STALL = 2'd3
  } disp_e;

  localparam int unsigned BLK_OFF = 6;
endpackage

// File: rtl/miss_track_match.sv
module miss_track_match #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned BLK_W   = 34,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ENTRIES-1:0]              ent_valid,
  input  logic [ENTRIES-1:0]              ent_io,
  input  logic [ENTRIES-1:0][BLK_W-1:0]   ent_blk,
  input  logic [BLK_W-1:0]                req_blk,
  input  logic                            req_io,
  output logic [ENTRIES-1:0]              hit_vec,
  output logic                            hit_any,
  output logic [IDX_W-1:0]                hit_idx,
  output logic                            free_any,
  output logic [IDX_W-1:0]                free_idx
);
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = ent_valid[g] && !ent_io[g] && !req_io &&
                          (ent_blk[g] == req_blk);
    end
  endgenerate

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
  end

  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!ent_valid[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
  end

  // R2: merging never lets two cacheable entries hold the same block
  assert_single_match_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/miss_track_order.sv
module miss_track_order #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic             not_empty,
  output logic [IDX_W-1:0] head_idx
);
  logic [IDX_W-1:0] slots [ENTRIES];
  logic [IDX_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign not_empty = (count != '0);
  assign head_idx  = slots[rd_ptr];

  // R5: order queue never holds more than one slot per entry
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (count < CNT_W'(ENTRIES)));
  // R5: the channel is never advanced with nothing to send
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    pop |-> not_empty);
endmodule

// File: rtl/miss_track_file.sv
module miss_track_file
  import miss_track_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PA_W    = 40,
  parameter int unsigned TAGS    = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned TAG_W  = $clog2(TAGS),
  localparam int unsigned BLK_W  = PA_W - BLK_OFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [PA_W-1:0]  req_addr,
  input  logic             req_io,
  input  logic [TAG_W-1:0] req_tag,
  output logic             req_stall,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [IDX_W-1:0] dn_idx,
  output logic [BLK_W-1:0] dn_blk,
  output logic             dn_io,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_idx,
  output logic             wake_valid,
  output logic [TAGS-1:0]  wake_mask
);
  logic [ENTRIES-1:0]            ent_valid;
  logic [ENTRIES-1:0]            ent_io;
  logic [ENTRIES-1:0][BLK_W-1:0] ent_blk;
  logic [TAGS-1:0]               ent_mask [ENTRIES];

  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any, free_any;
  logic [IDX_W-1:0]   hit_idx, free_idx;
  logic [BLK_W-1:0]   req_blk;
  logic [TAGS-1:0]    tag_bit;
  disp_e              disp;
  logic               do_alloc, do_merge, pop;
  logic               wake_valid_q;
  logic [TAGS-1:0]    wake_mask_q;

  assign req_blk = req_addr[PA_W-1:BLK_OFF];
  assign tag_bit = TAGS'(1) << req_tag;

  miss_track_match #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) u_match (
    .clk(clk), .rst(rst),
    .ent_valid(ent_valid), .ent_io(ent_io), .ent_blk(ent_blk),
    .req_blk(req_blk), .req_io(req_io),
    .hit_vec(hit_vec), .hit_any(hit_any), .hit_idx(hit_idx),
    .free_any(free_any), .free_idx(free_idx)
  );

  always_comb begin
    if (!req_valid)          disp = DISP_NONE;
    else if (hit_any)        disp = DISP_MERGE;
    else if (free_any)       disp = DISP_ALLOC;
    else                     disp = DISP_STALL;
  end

  assign do_alloc  = (disp == DISP_ALLOC);
  assign do_merge  = (disp == DISP_MERGE);
  assign req_stall = (disp == DISP_STALL);
  assign pop       = dn_valid && dn_ready;

  miss_track_order #(.ENTRIES(ENTRIES)) u_order (
    .clk(clk), .rst(rst),
    .push(do_alloc), .push_idx(free_idx), .pop(pop),
    .not_empty(dn_valid), .head_idx(dn_idx)
  );

  assign dn_blk = ent_blk[dn_idx];
  assign dn_io  = ent_io[dn_idx];

  // Entry state with reset: only the valid bits
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
    end else begin
      if (do_alloc)   ent_valid[free_idx] <= 1'b1;
      if (fill_valid) ent_valid[fill_idx] <= 1'b0;
    end
  end

  // Entry payload: plain storage, no reset needed
  always_ff @(posedge clk) begin
    if (do_alloc) begin
      ent_blk[free_idx]  <= req_blk;
      ent_io[free_idx]   <= req_io;
      ent_mask[free_idx] <= tag_bit;
    end
    if (do_merge)
      ent_mask[hit_idx] <= ent_mask[hit_idx] | tag_bit;
  end

  // Registered wakeup, folding in a same-cycle merge to the filled entry
  always_ff @(posedge clk) begin
    if (rst) begin
      wake_valid_q <= 1'b0;
      wake_mask_q  <= '0;
    end else begin
      wake_valid_q <= fill_valid;
      if (fill_valid)
        wake_mask_q <= ent_mask[fill_idx] |
                       ((do_merge && hit_idx == fill_idx) ? tag_bit : '0);
      else
        wake_mask_q <= '0;
    end
  end

  assign wake_valid = wake_valid_q;
  assign wake_mask  = wake_mask_q;

  // R7: fills target only held entries (input assumption)
  assert_fill_held_R7: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> ent_valid[fill_idx]);
  // R7: a wakeup is always one cycle after a fill
  assert_wake_after_fill_R7: assert property (@(posedge clk) disable iff (rst)
    wake_valid |-> $past(fill_valid));
  // R6: a stall only happens with every entry in use
  assert_stall_only_full_R6: assert property (@(posedge clk) disable iff (rst)
    req_stall |-> (&ent_valid));
  // R4: uncached requests never merge
  assert_io_never_merges_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_io) |-> !do_merge);
  // R5: a waiting request holds still
  assert_dn_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_idx) && $stable(dn_blk)));
  // R2: compared addresses are fully known
  assert_addr_known_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !$isunknown(req_addr));
endmodule

// File: tb/miss_track_file_bench.sv
module miss_track_file_bench;
  localparam int NE = 8;
  localparam int PW = 40;
  localparam int NT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_io = 0, dn_ready = 0, fill_valid = 0;
  logic [PW-1:0] req_addr = '0;
  logic [3:0] req_tag = '0;
  logic [2:0] fill_idx = '0;
  logic req_stall, dn_valid, dn_io, wake_valid;
  logic [2:0] dn_idx;
  logic [PW-7:0] dn_blk;
  logic [NT-1:0] wake_mask;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  miss_track_file u_miss_track_file (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_io(req_io), .req_tag(req_tag), .req_stall(req_stall),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_idx(dn_idx),
    .dn_blk(dn_blk), .dn_io(dn_io), .fill_valid(fill_valid),
    .fill_idx(fill_idx), .wake_valid(wake_valid), .wake_mask(wake_mask)
  );

  // Bench-side model of the file
  logic          m_valid [NE];
  logic          m_io    [NE];
  logic          m_iss   [NE];
  logic [PW-7:0] m_blk   [NE];
  logic [NT-1:0] m_mask  [NE];
  int            q[$];
  logic          e_wv = 0;
  logic [NT-1:0] e_wm = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] blk_addr(input int k, input int off);
    return PW'(40'h10_0000_0000 + (longint'(k) << 6) + off);
  endfunction

  task automatic step(input logic rv, input logic [PW-1:0] ra, input logic rio,
                      input logic [3:0] rt, input logic fv, input logic [2:0] fi,
                      input logic dr);
    int hit, fr;
    logic [PW-7:0] b;
    logic [NT-1:0] tb;
    @(negedge clk);
    req_valid = rv; req_addr = ra; req_io = rio; req_tag = rt;
    fill_valid = fv; fill_idx = fi; dn_ready = dr;
    #1;
    b = ra[PW-1:6];
    tb = NT'(1) << rt;
    hit = -1; fr = -1;
    for (int i = 0; i < NE; i++)
      if (m_valid[i] && !m_io[i] && !rio && m_blk[i] == b) hit = i;
    for (int i = NE - 1; i >= 0; i--)
      if (!m_valid[i]) fr = i;
    if (fr < 0 && hit < 0)
      chk(req_stall == rv, "R6 stall when full", req_stall, rv);
    else
      chk(req_stall == 1'b0, "R3 accept with room or merge", req_stall, 0);
    chk(dn_valid == (q.size() > 0), "R5 dn_valid", dn_valid, q.size() > 0);
    if (q.size() > 0) begin
      chk(dn_idx == q[0][2:0], "R3/R5 dn_idx oldest, lowest free", dn_idx, q[0]);
      chk(dn_blk == m_blk[q[0]], "R5 dn_blk", dn_blk, m_blk[q[0]]);
      chk(dn_io == m_io[q[0]], "R4 dn_io", dn_io, m_io[q[0]]);
    end
    chk(wake_valid == e_wv, "R7 wake pulse", wake_valid, e_wv);
    if (e_wv) chk(wake_mask == e_wm, "R7 wake mask with R2 merged tags", wake_mask, e_wm);
    // model update at the coming edge
    e_wv = fv;
    e_wm = fv ? (m_mask[fi] | ((rv && hit == int'(fi)) ? tb : '0)) : '0;
    if (q.size() > 0 && dr) begin
      m_iss[q[0]] = 1;
      void'(q.pop_front());
    end
    if (rv && hit >= 0) m_mask[hit] |= tb;
    else if (rv && fr >= 0) begin
      m_valid[fr] = 1; m_io[fr] = rio; m_iss[fr] = 0;
      m_blk[fr] = b; m_mask[fr] = tb;
      q.push_back(fr);
    end
    if (fv) m_valid[fi] = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    int seed;
    int cand[$];
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < NE; i++) begin
      m_valid[i] = 0; m_io[i] = 0; m_iss[i] = 0; m_blk[i] = '0; m_mask[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1: reset state
    chk(req_stall == 0, "R1 stall after reset", req_stall, 0);
    chk(dn_valid == 0, "R1 dn_valid after reset", dn_valid, 0);
    chk(wake_valid == 0, "R1 wake_valid after reset", wake_valid, 0);

    // R6: fill all entries with distinct blocks, nothing issued
    for (int k = 0; k < NE; k++) step(1, blk_addr(k, k * 4), 0, 4'(k), 0, 0, 0);
    step(1, blk_addr(20, 0), 0, 4'd1, 0, 0, 0);       // R6 stall
    step(1, blk_addr(2, 63), 0, 4'd9, 0, 0, 0);       // R2/R6 merge while full
    step(1, blk_addr(3, 8), 1, 4'd11, 0, 0, 0);       // R4 io stalls, no merge
    idle(NE);
    for (int k = 0; k < NE; k++) step(0, '0, 0, 0, 1, 3'(k), 1);  // R7 wakeups
    idle(2);

    // R4: io and cacheable to one block stay separate
    step(1, blk_addr(5, 0), 0, 4'd2, 0, 0, 0);
    step(1, blk_addr(5, 16), 1, 4'd3, 0, 0, 0);
    step(1, blk_addr(5, 32), 0, 4'd4, 0, 0, 0);
    step(1, blk_addr(5, 48), 1, 4'd6, 0, 0, 0);
    idle(4);
    // R7: fill and merge into the same entry in one cycle
    step(1, blk_addr(5, 1), 0, 4'd7, 1, 3'd0, 1);
    for (int k = 1; k < 3; k++) step(0, '0, 0, 0, 1, 3'(k), 1);
    idle(2);

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic rv, rio, fv, dr;
      logic [2:0] fi;
      rv = ($urandom % 3) != 0;
      rio = ($urandom % 6) == 0;
      dr = ($urandom % 4) != 0;
      cand.delete();
      for (int i = 0; i < NE; i++) if (m_valid[i] && m_iss[i]) cand.push_back(i);
      fv = (cand.size() > 0) && (($urandom % 3) == 0);
      fi = fv ? 3'(cand[$urandom % cand.size()]) : 3'd0;
      step(rv, blk_addr(int'($urandom % 6), int'($urandom % 64)), rio,
           4'($urandom), fv, fi, dr);
    end
    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule